// File: doc/BRIEF.md
# Sequential Quotient and Remainder Engine

This block takes a dividend and a divisor, and after a fixed number of clock cycles it returns the quotient and the remainder together. The caller chooses an operand width of 8, 16, 32 or 64 bits and picks signed or unsigned interpretation. Operands are cut down to the chosen width first. Results come back zero-extended to 64 bits. The engine retires one quotient bit per clock through a restoring shift-subtract loop that works on magnitudes, then spends one more cycle restoring signs.

A caller raises `go_i` for one cycle while `busy_o` is low, along with the operands and the mode selects. `busy_o` stays high while the loop runs. `done_o` pulses once when the results are valid, and the results hold until the next completion. A zero divisor does not stop anything: it produces a defined pair of results. Signed overflow (most negative divided by minus one) wraps in two's complement.

Top module: `divrem_unit`

## Requirements
- R1: With `sgn_i`=0, the quotient is floor(a/b) and the remainder is a mod b, taken over the truncated unsigned operands. The width code `wsel_i` encodes 0=8, 1=16, 2=32 and 3=64 bits.
- R2: Operand bits at or above the selected width have no effect on either result.
- R3: With `sgn_i`=1, the operands are two's complement values at the selected width. The quotient truncates toward zero, the remainder takes the sign of the dividend, and both are returned as W-bit two's complement patterns.
- R4: Signed, most negative value divided by all ones (−1): the quotient is the most negative pattern (only bit W−1 set) and the remainder is 0.
- R5: A divisor whose truncated value is zero gives a quotient with all 64 bits set and a remainder equal to the truncated dividend, zero-extended. This holds in both signed and unsigned mode.
- R6: Apart from the R5 quotient, every result bit at or above the selected width is 0.
- R7: `done_o` rises exactly W+1 clock edges after the edge that accepts `go_i`, and `busy_o` is high from the accepting edge until that point.
- R8: `done_o` is high for exactly one cycle, and `busy_o` is low whenever `done_o` is high.
- R9: `go_i` and operand changes while `busy_o` is high are ignored. A new request can be accepted in the cycle where `done_o` is high.
- R10: A synchronous active-low reset clears `busy_o`, `done_o`, `quo_o` and `rem_o` to zero.
- R11: `quo_o` and `rem_o` change only on the edge that raises `done_o`, and hold their value otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| go_i | input | 1 | Request pulse, sampled while not busy |
| wsel_i | input | 2 | Operand width code (0=8, 1=16, 2=32, 3=64) |
| sgn_i | input | 1 | 1 selects signed division |
| num_i | input | 64 | Dividend |
| den_i | input | 64 | Divisor |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle result-valid pulse |
| quo_o | output | 64 | Quotient, zero-extended |
| rem_o | output | 64 | Remainder, zero-extended |

## Verification
The assertions check the following on every cycle:
- the done pulse shape and how it relates to `busy_o`;
- the W+1 latency, measured with a counter;
- the divide-by-zero pair;
- the zero upper bits;
- the hold of the results between completions;
- the overflow case;
- the unsigned identity q·b+r = a with r < b.

Signed rounding toward zero and the remainder sign, the independence from upper operand bits, requests ignored while busy, back-to-back acceptance in the done cycle, and the reset values can only be shown by the bench. The bench does this by comparing every cycle against its arithmetic model, using directed and random operands.

// File: rtl/divrem_pkg.sv
// Package for the quotient/remainder engine: shared width codes, FSM
// states and the width-code decoding helper.
package divrem_pkg;

    // Width select codes; the number of operand bits is 8 << code.
    typedef enum logic [1:0] {
        WSEL_8  = 2'd0,
        WSEL_16 = 2'd1,
        WSEL_32 = 2'd2,
        WSEL_64 = 2'd3
    } wsel_e;

    // Top-level sequencing states.
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_LOOP = 2'd1,
        ST_SIGN = 2'd2
    } seq_state_e;

    // Number of operand bits that a width code selects.
    function automatic int unsigned lane_bits(input logic [1:0] code);
        return 32'd8 << code;
    endfunction

endpackage

// File: rtl/divrem_prep.sv
// Operand preparation (combinational).
// Truncates both operands to the selected width, finds their signs in
// signed mode, and converts them to unsigned magnitudes. Also produces the
// lane mask and the zero-divisor flag.
// Assumes: DATA_W is 64, so the four lane widths 8..64 all fit.
module divrem_prep #(
    parameter int DATA_W = 64
) (
    input  logic [1:0]        wsel_i,
    input  logic              sgn_i,
    input  logic [DATA_W-1:0] num_i,
    input  logic [DATA_W-1:0] den_i,
    output logic [DATA_W-1:0] mask_o,
    output logic [DATA_W-1:0] num_trunc_o,
    output logic [DATA_W-1:0] num_mag_o,
    output logic [DATA_W-1:0] den_mag_o,
    output logic              num_neg_o,
    output logic              den_neg_o,
    output logic              den_zero_o
);
    localparam int N_LANES = 4;

    logic [DATA_W-1:0] mask_tab [N_LANES];
    logic [DATA_W-1:0] msb_tab  [N_LANES];

    // One mask / sign-bit pattern per supported lane width.
    for (genvar g = 0; g < N_LANES; g++) begin : g_lane
        localparam int LANE_W = 8 << g;
        assign mask_tab[g] = {DATA_W{1'b1}} >> (DATA_W - LANE_W);
        assign msb_tab[g]  = {{(DATA_W-1){1'b0}}, 1'b1} << (LANE_W - 1);
    end

    logic [DATA_W-1:0] msb;
    logic [DATA_W-1:0] den_trunc;

    // Select lane patterns and truncate operands.
    always_comb begin
        mask_o      = mask_tab[wsel_i];
        msb         = msb_tab[wsel_i];
        num_trunc_o = num_i & mask_o;
        den_trunc   = den_i & mask_o;
        den_zero_o  = (den_trunc == '0);
    end

    // Derive signs and magnitudes at the selected width.
    always_comb begin
        num_neg_o = sgn_i && ((num_trunc_o & msb) != '0);
        den_neg_o = sgn_i && ((den_trunc & msb) != '0);
        num_mag_o = num_neg_o ? ((-num_trunc_o) & mask_o) : num_trunc_o;
        den_mag_o = den_neg_o ? ((-den_trunc) & mask_o) : den_trunc;
    end

endmodule

// File: rtl/divrem_core.sv
// Restoring shift-subtract engine, one quotient bit per step.
// At load, the dividend magnitude is left-aligned in the quotient shift
// register, so that after cnt_init_i steps the low cnt_init_i bits hold
// the quotient and the partial remainder holds the remainder.
// Assumes: cnt_init_i is between 1 and DATA_W, and step_i is only raised
// while steps remain.
module divrem_core #(
    parameter int DATA_W = 64,
    parameter int CNT_W  = $clog2(DATA_W) + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic              step_i,
    input  logic [DATA_W-1:0] num_mag_i,
    input  logic [DATA_W-1:0] den_mag_i,
    input  logic [CNT_W-1:0]  cnt_init_i,
    output logic [DATA_W-1:0] quo_mag_o,
    output logic [DATA_W-1:0] rem_mag_o,
    output logic              last_o
);
    logic [DATA_W:0]   prem_q;
    logic [DATA_W-1:0] qsh_q;
    logic [DATA_W-1:0] dvs_q;
    logic [CNT_W-1:0]  cnt_q;

    logic [DATA_W:0]   trial;
    logic [DATA_W:0]   trial_sub;
    logic              fits;

    // Shift in the next dividend bit and try subtracting the divisor.
    always_comb begin
        trial     = {prem_q[DATA_W-1:0], qsh_q[DATA_W-1]};
        fits      = trial >= {1'b0, dvs_q};
        trial_sub = trial - {1'b0, dvs_q};
    end

    // Load operands, or take one restoring step per cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prem_q <= '0;
            qsh_q  <= '0;
            dvs_q  <= '0;
            cnt_q  <= '0;
        end else if (load_i) begin
            prem_q <= '0;
            qsh_q  <= num_mag_i << (CNT_W'(DATA_W) - cnt_init_i);
            dvs_q  <= den_mag_i;
            cnt_q  <= cnt_init_i;
        end else if (step_i) begin
            prem_q <= fits ? trial_sub : trial;
            qsh_q  <= {qsh_q[DATA_W-2:0], fits};
            cnt_q  <= cnt_q - 1'b1;
        end
    end

    assign quo_mag_o = qsh_q;
    assign rem_mag_o = prem_q[DATA_W-1:0];
    assign last_o    = (cnt_q == CNT_W'(1));

endmodule

// File: rtl/divrem_fix.sv
// Result formatting (combinational).
// Applies the signs to the unsigned magnitudes: the quotient is negated
// when the operand signs differ, and the remainder follows the dividend
// sign. Results are masked to the lane. A zero divisor overrides both
// results: all-ones quotient, truncated dividend as remainder.
// Assumes: the sign flags are already zero in unsigned mode.
module divrem_fix #(
    parameter int DATA_W = 64
) (
    input  logic [DATA_W-1:0] quo_mag_i,
    input  logic [DATA_W-1:0] rem_mag_i,
    input  logic [DATA_W-1:0] mask_i,
    input  logic [DATA_W-1:0] num_trunc_i,
    input  logic              num_neg_i,
    input  logic              den_neg_i,
    input  logic              den_zero_i,
    output logic [DATA_W-1:0] quo_o,
    output logic [DATA_W-1:0] rem_o
);
    logic [DATA_W-1:0] quo_signed;
    logic [DATA_W-1:0] rem_signed;

    // Restore signs in two's complement and clip to the lane.
    always_comb begin
        quo_signed = (num_neg_i ^ den_neg_i) ? -quo_mag_i : quo_mag_i;
        rem_signed = num_neg_i ? -rem_mag_i : rem_mag_i;
        quo_signed = quo_signed & mask_i;
        rem_signed = rem_signed & mask_i;
    end

    // Apply the defined zero-divisor results.
    always_comb begin
        if (den_zero_i) begin
            quo_o = '1;
            rem_o = num_trunc_i;
        end else begin
            quo_o = quo_signed;
            rem_o = rem_signed;
        end
    end

endmodule

// File: rtl/divrem_unit.sv
// Top level of the sequential quotient/remainder engine.
// Accepts a request when idle, then runs W restoring steps followed by a
// single sign fix-up cycle. It pulses done_o and holds the results until
// the next completion. Requests that arrive while busy are dropped.
// Assumes: DATA_W is 64, and the caller holds operands only for the
// accepting cycle.
module divrem_unit #(
    parameter int DATA_W = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              go_i,
    input  logic [1:0]        wsel_i,
    input  logic              sgn_i,
    input  logic [DATA_W-1:0] num_i,
    input  logic [DATA_W-1:0] den_i,
    output logic              busy_o,
    output logic              done_o,
    output logic [DATA_W-1:0] quo_o,
    output logic [DATA_W-1:0] rem_o
);
    import divrem_pkg::*;

    localparam int CNT_W = $clog2(DATA_W) + 1;

    seq_state_e state_q;
    logic       accept;
    logic       done_q;

    logic [DATA_W-1:0] p_mask, p_trunc, p_nmag, p_dmag;
    logic              p_nneg, p_dneg, p_dzero;

    logic [DATA_W-1:0] mask_q, trunc_q;
    logic              nneg_q, dneg_q, dzero_q;

    logic [DATA_W-1:0] c_quo, c_rem;
    logic              c_last;
    logic [DATA_W-1:0] f_quo, f_rem;
    logic [DATA_W-1:0] quo_q, rem_q;

    assign accept = go_i && (state_q == ST_IDLE);

    divrem_prep #(.DATA_W(DATA_W)) u_prep (
        .wsel_i      (wsel_i),
        .sgn_i       (sgn_i),
        .num_i       (num_i),
        .den_i       (den_i),
        .mask_o      (p_mask),
        .num_trunc_o (p_trunc),
        .num_mag_o   (p_nmag),
        .den_mag_o   (p_dmag),
        .num_neg_o   (p_nneg),
        .den_neg_o   (p_dneg),
        .den_zero_o  (p_dzero)
    );

    divrem_core #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_core (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (accept),
        .step_i     (state_q == ST_LOOP),
        .num_mag_i  (p_nmag),
        .den_mag_i  (p_dmag),
        .cnt_init_i (CNT_W'(lane_bits(wsel_i))),
        .quo_mag_o  (c_quo),
        .rem_mag_o  (c_rem),
        .last_o     (c_last)
    );

    divrem_fix #(.DATA_W(DATA_W)) u_fix (
        .quo_mag_i   (c_quo),
        .rem_mag_i   (c_rem),
        .mask_i      (mask_q),
        .num_trunc_i (trunc_q),
        .num_neg_i   (nneg_q),
        .den_neg_i   (dneg_q),
        .den_zero_i  (dzero_q),
        .quo_o       (f_quo),
        .rem_o       (f_rem)
    );

    // Sequence idle -> loop (W steps) -> sign fix-up -> idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            case (state_q)
                ST_IDLE: if (accept) state_q <= ST_LOOP;
                ST_LOOP: if (c_last) state_q <= ST_SIGN;
                ST_SIGN: state_q <= ST_IDLE;
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // Capture the per-request flags that the fix-up stage needs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q  <= '0;
            trunc_q <= '0;
            nneg_q  <= 1'b0;
            dneg_q  <= 1'b0;
            dzero_q <= 1'b0;
        end else if (accept) begin
            mask_q  <= p_mask;
            trunc_q <= p_trunc;
            nneg_q  <= p_nneg;
            dneg_q  <= p_dneg;
            dzero_q <= p_dzero;
        end
    end

    // Register results and the one-cycle completion pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_q <= 1'b0;
            quo_q  <= '0;
            rem_q  <= '0;
        end else begin
            done_q <= (state_q == ST_SIGN);
            if (state_q == ST_SIGN) begin
                quo_q <= f_quo;
                rem_q <= f_rem;
            end
        end
    end

    assign busy_o = (state_q != ST_IDLE);
    assign done_o = done_q;
    assign quo_o  = quo_q;
    assign rem_o  = rem_q;

endmodule

// File: rtl/divrem_chk.sv
// Property checker for divrem_unit, attached with bind.
// Records the operands of each accepted request and counts the cycles
// since acceptance, then checks the results and timing at completion.
module divrem_chk #(
    parameter int DATA_W = 64
) (
    input logic              clk,
    input logic              rst_n,
    input logic              go_i,
    input logic [1:0]        wsel_i,
    input logic              sgn_i,
    input logic [DATA_W-1:0] num_i,
    input logic [DATA_W-1:0] den_i,
    input logic              busy_o,
    input logic              done_o,
    input logic [DATA_W-1:0] quo_o,
    input logic [DATA_W-1:0] rem_o
);
    import divrem_pkg::*;

    logic [DATA_W-1:0] cap_a, cap_b, cap_mask, cap_msb;
    logic              cap_s;
    logic [7:0]        cap_w;
    logic [7:0]        lat_cnt;
    logic [2*DATA_W-1:0] recon;

    // Record truncated operands and restart the latency count on accept.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cap_a    <= '0;
            cap_b    <= '0;
            cap_mask <= '0;
            cap_msb  <= '0;
            cap_s    <= 1'b0;
            cap_w    <= '0;
            lat_cnt  <= '0;
        end else if (go_i && !busy_o) begin
            cap_mask <= {DATA_W{1'b1}} >> (DATA_W - lane_bits(wsel_i));
            cap_msb  <= {{(DATA_W-1){1'b0}}, 1'b1} << (lane_bits(wsel_i) - 1);
            cap_a    <= num_i & ({DATA_W{1'b1}} >> (DATA_W - lane_bits(wsel_i)));
            cap_b    <= den_i & ({DATA_W{1'b1}} >> (DATA_W - lane_bits(wsel_i)));
            cap_s    <= sgn_i;
            cap_w    <= 8'(lane_bits(wsel_i));
            lat_cnt  <= '0;
        end else if (busy_o) begin
            lat_cnt  <= lat_cnt + 8'd1;
        end
    end

    // Rebuild the dividend from the quotient and remainder of an unsigned request.
    always_comb recon = (2*DATA_W)'(quo_o) * (2*DATA_W)'(cap_b) + (2*DATA_W)'(rem_o);

    // R8
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R8
    done_not_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !busy_o);

    // R7
    latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (lat_cnt == cap_w + 8'd1));

    // R5
    zero_div_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && cap_b == '0) |-> (quo_o == '1 && rem_o == cap_a));

    // R6
    upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && cap_b != '0) |-> ((quo_o & ~cap_mask) == '0 && (rem_o & ~cap_mask) == '0));

    // R1
    unsigned_ident_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !cap_s && cap_b != '0) |-> (recon == (2*DATA_W)'(cap_a) && rem_o < cap_b));

    // R4
    overflow_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && cap_s && cap_a == cap_msb && cap_b == cap_mask) |-> (quo_o == cap_msb && rem_o == '0));

    // R11
    result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(quo_o) || !$stable(rem_o)) |-> done_o);

endmodule

bind divrem_unit divrem_chk #(.DATA_W(DATA_W)) u_divrem_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .go_i   (go_i),
    .wsel_i (wsel_i),
    .sgn_i  (sgn_i),
    .num_i  (num_i),
    .den_i  (den_i),
    .busy_o (busy_o),
    .done_o (done_o),
    .quo_o  (quo_o),
    .rem_o  (rem_o)
);

// File: tb/divrem_unit_bench.sv
`timescale 1ns/1ps
// Bench for divrem_unit. A behavioural model predicts busy, done and the
// results from integer arithmetic, and is compared on every falling edge.
module divrem_unit_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        go = 1'b0;
    logic [1:0]  wsel = 2'd0;
    logic        sgn = 1'b0;
    logic [63:0] num = '0;
    logic [63:0] den = '0;
    logic        busy, done;
    logic [63:0] quo, rem;

    int n_vec = 0;
    int n_bad = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    divrem_unit u_divrem_unit (
        .clk(clk), .rst_n(rst_n), .go_i(go), .wsel_i(wsel), .sgn_i(sgn),
        .num_i(num), .den_i(den), .busy_o(busy), .done_o(done),
        .quo_o(quo), .rem_o(rem)
    );

    // Arithmetic reference: truncation toward zero, zero-divisor rule.
    function automatic void ref_div(input logic [1:0] wc, input logic s,
                                    input logic [63:0] a, input logic [63:0] b,
                                    output logic [63:0] q, output logic [63:0] r);
        int w = 8 << wc;
        logic [63:0] m = (w == 64) ? 64'hFFFF_FFFF_FFFF_FFFF : ((64'd1 << w) - 64'd1);
        logic [63:0] at = a & m;
        logic [63:0] bt = b & m;
        longint sa, sb;
        if (bt == 0) begin
            q = '1;
            r = at;
        end else if (!s) begin
            q = at / bt;
            r = at % bt;
        end else begin
            sa = $signed(at << (64 - w)) >>> (64 - w);
            sb = $signed(bt << (64 - w)) >>> (64 - w);
            if (sa == 64'sh8000_0000_0000_0000 && sb == -1) begin
                q = at;
                r = '0;
            end else begin
                q = 64'(sa / sb) & m;
                r = 64'(sa % sb) & m;
            end
        end
    endfunction

    // Model state, advanced on each rising edge.
    bit          m_busy = 0, m_done = 0, m_live = 0;
    int          m_left = 0;
    logic [63:0] exp_q = '0, exp_r = '0, pend_q, pend_r;
    string       cur_tag = "R1", pend_tag = "R1", res_tag = "R10";

    always @(posedge clk) begin
        m_live = 1;
        if (!rst_n) begin
            m_busy = 0; m_done = 0; m_left = 0;
            exp_q = '0; exp_r = '0; res_tag = "R10";
        end else begin
            m_done = 0;
            if (m_busy) begin
                m_left--;
                if (m_left == 0) begin
                    m_busy = 0; m_done = 1;
                    exp_q = pend_q; exp_r = pend_r; res_tag = pend_tag;
                end
            end else if (go) begin
                ref_div(wsel, sgn, num, den, pend_q, pend_r);
                pend_tag = cur_tag;
                m_busy = 1;
                m_left = (8 << wsel) + 1;
            end
        end
    end

    // Cycle-by-cycle comparison, away from the active edge.
    always @(negedge clk) begin
        if (m_live && !finished) begin
            n_vec++;
            if (busy !== m_busy || done !== m_done) begin
                n_bad++;
                $display("FAIL %s: busy/done actual %b/%b expected %b/%b",
                         rst_n ? "R7/R8" : "R10", busy, done, m_busy, m_done);
            end
            if (quo !== exp_q || rem !== exp_r) begin
                n_bad++;
                $display("FAIL %s: q/r actual %h/%h expected %h/%h",
                         res_tag, quo, rem, exp_q, exp_r);
            end
        end
    end

    // Issue one request when idle, holding go for a single cycle.
    task automatic issue(input logic [1:0] wc, input logic s,
                         input logic [63:0] a, input logic [63:0] b, input string tag);
        @(negedge clk);
        while (busy) @(negedge clk);
        wsel = wc; sgn = s; num = a; den = b; cur_tag = tag; go = 1'b1;
        @(negedge clk);
        go = 1'b0;
        num = ~a; den = ~b;
    endtask

    // R9: pulse go with other operands while a request is running.
    task automatic poke_while_busy();
        repeat (3) begin
            @(negedge clk);
            go = 1'b1; wsel = 2'd0; sgn = ~sgn; num = 64'h55; den = 64'h3;
        end
        @(negedge clk);
        go = 1'b0;
    endtask

    initial begin
        repeat (4) @(negedge clk);              // R10 reset state is compared here
        rst_n = 1'b1;
        // R1 unsigned, each width
        issue(2'd0, 0, 64'd200, 64'd7, "R1");
        issue(2'd1, 0, 64'd65535, 64'd256, "R1");
        issue(2'd2, 0, 64'hFFFF_FFFF, 64'd10, "R1");
        issue(2'd3, 0, 64'hFFFF_FFFF_FFFF_FFFF, 64'd3, "R1");
        issue(2'd3, 0, 64'd5, 64'd9, "R1");
        // R2 upper operand bits ignored
        issue(2'd0, 0, 64'hABCD_0000_0000_1264, 64'hFF00_0000_0000_0105, "R2");
        issue(2'd1, 1, 64'h1234_5678_9ABC_8001, 64'h7777_0000_0000_0003, "R2");
        // R3 signed rounding toward zero, remainder sign of dividend
        issue(2'd0, 1, 64'hF9, 64'h02, "R3");    // -7 / 2  -> -3, -1
        issue(2'd0, 1, 64'h07, 64'hFE, "R3");    //  7 / -2 -> -3,  1
        issue(2'd1, 1, 64'hFFF9, 64'hFFFE, "R3"); // -7 / -2 -> 3, -1
        issue(2'd3, 1, 64'hFFFF_FFFF_FFFF_FF9C, 64'd7, "R3");
        // R4 most negative by minus one, each width
        issue(2'd0, 1, 64'h80, 64'hFF, "R4");
        issue(2'd1, 1, 64'h8000, 64'hFFFF, "R4");
        issue(2'd2, 1, 64'h8000_0000, 64'hFFFF_FFFF, "R4");
        issue(2'd3, 1, 64'h8000_0000_0000_0000, 64'hFFFF_FFFF_FFFF_FFFF, "R4");
        // R5 zero divisor, including upper bits that truncate away
        issue(2'd0, 0, 64'h1_23, 64'h100, "R5");
        issue(2'd2, 1, 64'h8000_0001, 64'h0, "R5");
        issue(2'd3, 1, 64'hFFFF_FFFF_FFFF_FFFE, 64'h0, "R5");
        // R6 negative signed results stay zero-extended
        issue(2'd1, 1, 64'hFF00, 64'h0003, "R6");
        // R9 go while busy is ignored
        issue(2'd3, 0, 64'd1000000, 64'd37, "R9");
        poke_while_busy();
        // R11 result hold across idle gap
        repeat (10) @(negedge clk);
        // R1/R3 random mix, back-to-back (R9 accept in done cycle)
        for (int i = 0; i < 300; i++) begin
            logic [63:0] ra = {$urandom, $urandom};
            logic [63:0] rb = {$urandom, $urandom} >> ($urandom % 64);
            issue(2'($urandom), 1'($urandom), ra, rb, "R3");
        end
        @(negedge clk);
        while (busy) @(negedge clk);
        repeat (3) @(negedge clk);
        if (!finished) begin
            finished = 1;
            $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        #(200000 * 5);
        if (!finished) begin
            finished = 1;
            n_bad++;
            $display("FAIL R7: watchdog expired, actual busy %b expected completion", busy);
            $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

endmodule